// File: doc/BRIEF.md
# Status Flag Two-Step Clear Controller

This block holds three sticky status flags for a serial port and turns them into one interrupt request and per-flag DMA requests. Flag 0 (transmit watermark) sets while the transmit FIFO level is at or below its watermark. Flag 1 (receive watermark) sets while the receive FIFO level is at or above its watermark. Flag 2 (receiver idle) sets on a one-cycle idle event.

Software clears a flag in two steps. First it reads the status register, which arms every flag set at that moment. Later it makes a data-register access of the matching kind. A flag routed to DMA is instead cleared by its DMA-done strobe. A condition that still holds sets the flag again at once. A data-register read made while the receive FIFO is empty raises a one-cycle underflow pulse, so that software can detect that the FIFO pointers are now misaligned.

Top module: `stsflag_ctl`

## Requirements
- R1: While reset is asserted and just after it is released, `flags`, `irq`, `dma_req` and `rx_underflow` are all 0.
- R2: One clock edge after its condition, a flag goes to 1 and stays at 1 until it is cleared. The conditions are: bit 0 when `tx_level <= tx_wmark`, bit 1 when `rx_level >= rx_wmark`, and bit 2 when `rx_idle_evt` is 1.
- R3: An armed flag clears on the edge of the matching data access. Bit 0 needs a `data_wr`. Bits 1 and 2 need a `data_rd`. An access of the other kind leaves the flag set.
- R4: A data access clears nothing unless a status read came before it. A status read in the same cycle as a data access does not count for that access, but it does arm the flags for a later access.
- R5: An arm survives accesses made between the status read and the matching data access, including data accesses of the other kind.
- R6: A status read arms only the flags that are 1 in that cycle. A flag that sets afterwards is not cleared by the following data access.
- R7: If `dma_sel[i]` is 1, a `dma_done[i]` pulse clears flag i without a status read. If `dma_sel[i]` is 0, `dma_done[i]` has no effect.
- R8: If a flag's set condition holds in the cycle of its clear event, the flag stays 1, and that clear event still removes the arm.
- R9: `irq` is the OR over i of `flags[i] & irq_en[i] & ~dma_sel[i]`. `dma_req[i]` is `flags[i] & dma_sel[i]`. Both follow `flags`, `irq_en` and `dma_sel` with no added cycle.
- R10: `rx_underflow` is 1 for exactly one cycle, on the edge after a `data_rd` made with `rx_level == 0`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_wmark | input | LVL_W | Transmit watermark |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_wmark | input | LVL_W | Receive watermark |
| rx_idle_evt | input | 1 | One-cycle receiver idle event |
| irq_en | input | 3 | Per-flag interrupt enable |
| dma_sel | input | 3 | Per-flag DMA routing select |
| dma_done | input | 3 | Per-flag DMA completion strobe |
| flags | output | 3 | Flag bits: 0 tx watermark, 1 rx watermark, 2 idle |
| irq | output | 1 | Interrupt request |
| dma_req | output | 3 | Per-flag DMA request |
| rx_underflow | output | 1 | Pulse for a data read from an empty receive FIFO |

## Verification
Set conditions, clears and the underflow pulse are all registered, so each shows at the outputs one rising edge after the cycle where its stimulus is presented. `irq` and `dma_req` are combinational from the flag registers and the enable inputs, so they are due in the same cycle as those. The bench changes inputs on the falling edge and samples registered results on the next falling edge, one rising edge later. It samples the combinational outputs one time unit after changing the enables, with no edge in between.

// File: rtl/stsflag_ctl_pkg.sv
package stsflag_ctl_pkg;

    localparam int NFLAG = 3;

    // flag positions
    localparam int F_TXW  = 0;
    localparam int F_RXW  = 1;
    localparam int F_IDLE = 2;

    // a 1 marks a flag cleared by a data write, a 0 one cleared by a data read
    localparam logic [NFLAG-1:0] CLR_BY_WR = 3'b001;

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    typedef struct packed {
        logic uflow;
    } top_t;

endpackage

// File: rtl/stsflag_cond.sv
module stsflag_cond
    import stsflag_ctl_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] tx_wmark_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_wmark_i,
    input  logic             idle_evt_i,
    output logic [NFLAG-1:0] set_o,
    output logic             rx_empty_o
);

    localparam logic [LVL_W-1:0] LVL_ZERO = '0;

    always_comb begin
        set_o         = '0;
        set_o[F_TXW]  = (tx_level_i <= tx_wmark_i);
        set_o[F_RXW]  = (rx_level_i >= rx_wmark_i);
        set_o[F_IDLE] = idle_evt_i;
        rx_empty_o    = (rx_level_i == LVL_ZERO);
    end

endmodule

// File: rtl/stsflag_cell.sv
module stsflag_cell
    import stsflag_ctl_pkg::*;
#(
    parameter bit CLR_ON_WR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    input  logic data_wr_i,
    input  logic dma_sel_i,
    input  logic dma_done_i,
    output logic flag_o
);

    cell_t st_d, st_q;
    logic  access;
    logic  sw_clr;
    logic  dma_clr;

    always_comb begin
        st_d    = st_q;
        access  = CLR_ON_WR ? data_wr_i : data_rd_i;
        // the arm is taken from the register, so a status read in this same cycle cannot satisfy it
        sw_clr  = st_q.armed && access;
        dma_clr = dma_sel_i && dma_done_i;
        if (sw_clr || dma_clr) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else if (stat_rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        // a condition that still holds outranks any clear
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/stsflag_ctl.sv
module stsflag_ctl
    import stsflag_ctl_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_wmark,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_wmark,
    input  logic             rx_idle_evt,
    input  logic [2:0]       irq_en,
    input  logic [2:0]       dma_sel,
    input  logic [2:0]       dma_done,
    output logic [2:0]       flags,
    output logic             irq,
    output logic [2:0]       dma_req,
    output logic             rx_underflow
);

    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_vec;
    logic             rx_empty;
    top_t             top_d, top_q;

    stsflag_cond #(.LVL_W(LVL_W)) u_cond (
        .tx_level_i (tx_level),
        .tx_wmark_i (tx_wmark),
        .rx_level_i (rx_level),
        .rx_wmark_i (rx_wmark),
        .idle_evt_i (rx_idle_evt),
        .set_o      (set_vec),
        .rx_empty_o (rx_empty)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_cell
        stsflag_cell #(.CLR_ON_WR(CLR_BY_WR[i])) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_vec[i]),
            .stat_rd_i  (stat_rd),
            .data_rd_i  (data_rd),
            .data_wr_i  (data_wr),
            .dma_sel_i  (dma_sel[i]),
            .dma_done_i (dma_done[i]),
            .flag_o     (flag_vec[i])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.uflow = data_rd && rx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign flags        = flag_vec;
    assign dma_req      = flag_vec & dma_sel;
    assign irq          = |(flag_vec & irq_en & ~dma_sel);
    assign rx_underflow = top_q.uflow;

endmodule

// File: rtl/stsflag_ctl_chk.sv
module stsflag_ctl_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_rd,
    input logic             data_wr,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] tx_wmark,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_idle_evt,
    input logic [2:0]       dma_sel,
    input logic [2:0]       dma_done,
    input logic [2:0]       flags,
    input logic             rx_underflow
);

    localparam logic [LVL_W-1:0] LZ = '0;

    // R3: the tx flag drops only after a data write or its DMA clear
    p_tx_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(data_wr || (dma_sel[0] && dma_done[0])));

    // R3: the rx watermark flag drops only after a data read or its DMA clear
    p_rx_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(data_rd || (dma_sel[1] && dma_done[1])));

    // R8: a tx condition that holds leaves the flag set on the next edge
    p_set_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_wmark) |=> flags[0]);

    // R2: an idle event sets bit 2
    p_idle_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idle_evt |=> flags[2]);

    // R7: a DMA strobe on a flag that is not routed to DMA is ignored
    p_dma_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && dma_done[1] && !dma_sel[1] && !data_rd) |=> flags[1]);

    // R10: a read from an empty receive FIFO is reported
    p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_level == LZ) |=> rx_underflow);

endmodule

bind stsflag_ctl stsflag_ctl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_rd      (data_rd),
    .data_wr      (data_wr),
    .tx_level     (tx_level),
    .tx_wmark     (tx_wmark),
    .rx_level     (rx_level),
    .rx_idle_evt  (rx_idle_evt),
    .dma_sel      (dma_sel),
    .dma_done     (dma_done),
    .flags        (flags),
    .rx_underflow (rx_underflow)
);

// File: tb/stsflag_ctl_test.sv
module stsflag_ctl_test;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stat_rd = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
    logic [LVL_W-1:0] tx_level = 5'd8, tx_wmark = 5'd2;
    logic [LVL_W-1:0] rx_level = 5'd0, rx_wmark = 5'd4;
    logic             rx_idle_evt = 1'b0;
    logic [2:0]       irq_en = 3'b111, dma_sel = 3'b000, dma_done = 3'b000;
    logic [2:0]       flags, dma_req;
    logic             irq, rx_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stsflag_ctl #(.LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .tx_level(tx_level), .tx_wmark(tx_wmark), .rx_level(rx_level), .rx_wmark(rx_wmark),
        .rx_idle_evt(rx_idle_evt), .irq_en(irq_en), .dma_sel(dma_sel), .dma_done(dma_done),
        .flags(flags), .irq(irq), .dma_req(dma_req), .rx_underflow(rx_underflow)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every flag set at the moment is armed, then read and write clear all of them
    task automatic clear_all();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        data_rd = 1'b1; data_wr = 1'b1; tick(); data_rd = 1'b0; data_wr = 1'b0;
    endtask

    task automatic set_tx();
        tx_level = 5'd2; tick(); tx_level = 5'd8;
    endtask

    task automatic t_reset();
        chk("R1 flags", {1'b0, flags}, 4'h0);
        chk("R1 irq", {3'b0, irq}, 4'h0);
        chk("R1 dma_req", {1'b0, dma_req}, 4'h0);
        chk("R1 underflow", {3'b0, rx_underflow}, 4'h0);
    endtask

    task automatic t_set();
        set_tx();
        chk("R2 tx set", {1'b0, flags}, 4'h1);
        tick();
        chk("R2 tx sticky", {1'b0, flags}, 4'h1);
        rx_level = 5'd4; tick(); rx_level = 5'd0;
        chk("R2 rx set", {1'b0, flags}, 4'h3);
        rx_idle_evt = 1'b1; tick(); rx_idle_evt = 1'b0;
        chk("R2 idle set", {1'b0, flags}, 4'h7);
        clear_all();
        chk("R2 cleanup", {1'b0, flags}, 4'h0);
    endtask

    task automatic t_two_step();
        set_tx();
        rx_idle_evt = 1'b1; tick(); rx_idle_evt = 1'b0;
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk("R3 read clears idle only / R5 tx arm kept", {1'b0, flags}, 4'h1);
        tick();
        chk("R5 idle gap keeps tx", {1'b0, flags}, 4'h1);
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R3 write clears tx", {1'b0, flags}, 4'h0);
    endtask

    task automatic t_wrong_kind();
        rx_idle_evt = 1'b1; tick(); rx_idle_evt = 1'b0;
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R3 write leaves idle", {1'b0, flags}, 4'h4);
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk("R3 read clears idle", {1'b0, flags}, 4'h0);
    endtask

    task automatic t_no_arm();
        set_tx();
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R4 unarmed write", {1'b0, flags}, 4'h1);
        stat_rd = 1'b1; data_wr = 1'b1; tick(); stat_rd = 1'b0; data_wr = 1'b0;
        chk("R4 same cycle", {1'b0, flags}, 4'h1);
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R4 armed by combined read", {1'b0, flags}, 4'h0);
    endtask

    task automatic t_late_set();
        set_tx();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        rx_idle_evt = 1'b1; tick(); rx_idle_evt = 1'b0;
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk("R6 late idle not cleared", {1'b0, flags}, 4'h5);
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R6 armed tx cleared", {1'b0, flags}, 4'h4);
        clear_all();
    endtask

    task automatic t_dma();
        dma_sel = 3'b010;
        rx_level = 5'd4; tick(); rx_level = 5'd0;
        chk("R9 dma_req", {1'b0, dma_req}, 4'h2);
        chk("R9 irq masked by dma_sel", {3'b0, irq}, 4'h0);
        dma_done = 3'b010; tick(); dma_done = 3'b000;
        chk("R7 dma clear", {1'b0, flags}, 4'h0);
        dma_sel = 3'b000;
        rx_level = 5'd4; tick(); rx_level = 5'd0;
        dma_done = 3'b010; tick(); dma_done = 3'b000;
        chk("R7 dma ignored", {1'b0, flags}, 4'h2);
        chk("R9 irq", {3'b0, irq}, 4'h1);
        clear_all();
    endtask

    task automatic t_reassert();
        tx_level = 5'd2; tick();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R8 set wins", {1'b0, flags}, 4'h1);
        tx_level = 5'd8;
        data_wr = 1'b1; tick(); data_wr = 1'b0;
        chk("R8 arm consumed", {1'b0, flags}, 4'h1);
        clear_all();
        chk("R8 cleanup", {1'b0, flags}, 4'h0);
    endtask

    task automatic t_irq();
        irq_en = 3'b001;
        rx_idle_evt = 1'b1; tick(); rx_idle_evt = 1'b0;
        chk("R9 irq disabled", {3'b0, irq}, 4'h0);
        irq_en = 3'b100; #1;
        chk("R9 irq enabled", {3'b0, irq}, 4'h1);
        dma_sel = 3'b100; #1;
        chk("R9 irq routed away", {3'b0, irq}, 4'h0);
        chk("R9 dma_req idle", {1'b0, dma_req}, 4'h4);
        dma_sel = 3'b000; irq_en = 3'b111;
        clear_all();
    endtask

    task automatic t_underflow();
        tick();
        rx_level = 5'd0;
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk("R10 pulse", {3'b0, rx_underflow}, 4'h1);
        tick();
        chk("R10 one cycle", {3'b0, rx_underflow}, 4'h0);
        rx_level = 5'd3;
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk("R10 not empty", {3'b0, rx_underflow}, 4'h0);
        rx_level = 5'd0;
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_two_step();
        t_wrong_kind();
        t_no_arm();
        t_late_set();
        t_dma();
        t_reassert();
        t_irq();
        t_underflow();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule